// File: doc/BRIEF.md
# Cross-Lane Reduction Tree

The block folds a vector of 32 signed 16-bit lanes into one scalar. The fold can be a widening sum, a sum clamped to 16 bits, a maximum or a minimum. Two extremum variants also return a one-hot lane mask that marks the lane holding the winning value. The same pipeline also folds a 64-bit predicate into one bit, either all-true or any-true. Every accepted operation also carries a tail mask, whose bit l is set when l is less than a count input n.

The fold runs on a balanced binary tree with five combining levels. Each level ends in a register, so the block accepts one new operation on every clock. Its result equals a flat left-to-right fold of the lanes. Lane k occupies bits `vec_i[16k+15:16k]`. The predicate, the count and the op code travel beside the tree in a matching delay line, so every output field of an operation leaves the block in the same cycle.

Top module: `xlane_fold`

## Requirements
- R1: Op codes on `op_i`: 0 sum, 1 saturating sum, 2 max, 3 min, 4 max-with-index, 5 min-with-index, 6 all-true, 7 any-true. An operation sampled with `in_valid` high at a rising edge appears with `out_valid` high after the 6th rising edge counted from, and including, that edge. One operation is accepted per cycle with no gaps needed, and `out_valid` follows `in_valid` with exactly that delay.
- R2: Op 0 returns on `res_o` the exact 32-bit two's-complement sum of all 32 lanes, each sign-extended before adding.
- R3: Op 1 returns the exact sum clamped to [-32768, 32767] and sign-extended to 32 bits. The clamp is applied once, to the full-precision total, so partial sums that leave the 16-bit range do not change the result.
- R4: Ops 2 and 3 return the largest or smallest lane value, sign-extended to 32 bits, with no widening.
- R5: Ops 4 and 5 return the same value as ops 2 and 3. `lane_mask_o` then has exactly one bit set, at the lane holding that value. When several lanes share it, the lowest lane index wins. For every other op `lane_mask_o` is zero.
- R6: Lanes are ordered as signed numbers (-32768 < -1 < 0 < 32767) in ops 2 to 5.
- R7: Op 6 sets `flag_o` to the AND of all 64 bits of `pred_i`, and op 7 sets it to their OR. For these two ops `res_o` is zero. For ops 0 to 5 `flag_o` is zero.
- R8: For every operation, bit l of `tail_o` is 1 exactly when l < n. An n of 64 or more sets all 64 bits, and n = 0 clears them all.
- R9: While `rst` is high at a clock edge, every output is cleared to zero, `out_valid` included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op_i | input | 3 | Operation code (see R1) |
| vec_i | input | 512 | 32 signed 16-bit lanes, lane k at bits 16k+15:16k |
| pred_i | input | 64 | Predicate for the boolean folds |
| n_i | input | 7 | Count for the tail mask |
| out_valid | output | 1 | Result fields valid |
| res_o | output | 32 | Scalar result, signed |
| lane_mask_o | output | 32 | One-hot winning lane for ops 4 and 5 |
| flag_o | output | 1 | Boolean fold result |
| tail_o | output | 64 | Tail mask |

## Verification
Vectors filled with +32767 or -32768 hit the ends of the widening sum. A design with too narrow an accumulator would wrap and return a value of the wrong sign. Half +32767 and half -32768 gives a total of -16 whose partial sums leave the 16-bit range, so a design that clamps at each level would return a value near a rail instead. Repeated extreme values at two lanes, and a vector of identical lanes, show whether ties go to the lower lane: a design that breaks ties the other way marks the wrong bit. A mix of -1, 0 and -32768 catches a comparison done unsigned, which would pick -1 as the maximum. Counts of 0, 1, 63, 64 and above 64 check both ends of the tail mask.

// File: rtl/xlane_pkg.sv
package xlane_pkg;

  typedef enum logic [2:0] {
    OP_SUM  = 3'd0,
    OP_SSUM = 3'd1,
    OP_MAX  = 3'd2,
    OP_MIN  = 3'd3,
    OP_AMAX = 3'd4,
    OP_AMIN = 3'd5,
    OP_ALL  = 3'd6,
    OP_ANY  = 3'd7
  } fold_op_e;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_MAX = 2'd1,
    K_MIN = 2'd2
  } comb_kind_e;

  function automatic comb_kind_e kind_of(fold_op_e op);
    case (op)
      OP_MAX, OP_AMAX: return K_MAX;
      OP_MIN, OP_AMIN: return K_MIN;
      default:         return K_ADD;
    endcase
  endfunction

endpackage

// File: rtl/xlane_node.sv
module xlane_node
  import xlane_pkg::*;
#(
  parameter int ACC_W = 21,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  comb_kind_e       kind,
  input  logic [ACC_W-1:0] a_val,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [ACC_W-1:0] b_val,
  input  logic [IDX_W-1:0] b_idx,
  output logic [ACC_W-1:0] y_val,
  output logic [IDX_W-1:0] y_idx
);

  // Operand a always covers the lower lanes, so a tie keeps a.
  logic take_b;

  always_comb begin
    case (kind)
      K_MAX:   take_b = (b_val > a_val);
      K_MIN:   take_b = (b_val < a_val);
      default: take_b = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (kind == K_ADD) y_val <= a_val + b_val;
    else               y_val <= take_b ? b_val : a_val;
    y_idx <= take_b ? b_idx : a_idx;
  end

endmodule

// File: rtl/xlane_tree.sv
module xlane_tree
  import xlane_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  comb_kind_e                    kind_i,
  input  logic [LANES*DATA_W-1:0]       vec_i,
  output logic [DATA_W+$clog2(LANES)-1:0] root_val,
  output logic [$clog2(LANES)-1:0]      root_idx
);

  localparam int LEVELS = $clog2(LANES);
  localparam int ACC_W  = DATA_W + LEVELS;
  localparam int IDX_W  = LEVELS;

  logic [ACC_W-1:0] leaf_v [LANES];
  logic [IDX_W-1:0] leaf_i [LANES];
  logic [ACC_W-1:0] node_v [1:LANES-1];
  logic [IDX_W-1:0] node_i [1:LANES-1];
  comb_kind_e       kreg   [1:LEVELS-1];

  // Leaves: sums see sign-extended lanes; max/min see the lane with its
  // sign bit inverted, so a plain unsigned compare orders signed values.
  for (genvar k = 0; k < LANES; k++) begin : g_leaf
    logic [DATA_W-1:0] raw;
    assign raw = vec_i[k*DATA_W +: DATA_W];
    assign leaf_v[k] = (kind_i == K_ADD)
      ? ACC_W'($signed(raw))
      : {{(ACC_W-DATA_W){1'b0}}, ~raw[DATA_W-1], raw[DATA_W-2:0]};
    assign leaf_i[k] = IDX_W'(k);
  end

  // Kind follows the data down the tree, one register per level.
  always_ff @(posedge clk) begin
    kreg[1] <= kind_i;
    for (int s = 2; s < LEVELS; s++) kreg[s] <= kreg[s-1];
  end

  // Heap-indexed nodes: node i combines 2i (lower lanes) and 2i+1.
  for (genvar i = 1; i < LANES; i++) begin : g_node
    localparam int ST = LEVELS - $clog2(i + 1);
    comb_kind_e       nk;
    logic [ACC_W-1:0] av, bv;
    logic [IDX_W-1:0] ai, bi;

    if (ST == 0) begin : g_k0
      assign nk = kind_i;
    end else begin : g_kn
      assign nk = kreg[ST];
    end

    if (2*i >= LANES) begin : g_from_leaf
      assign av = leaf_v[2*i - LANES];
      assign ai = leaf_i[2*i - LANES];
      assign bv = leaf_v[2*i + 1 - LANES];
      assign bi = leaf_i[2*i + 1 - LANES];
    end else begin : g_from_node
      assign av = node_v[2*i];
      assign ai = node_i[2*i];
      assign bv = node_v[2*i + 1];
      assign bi = node_i[2*i + 1];
    end

    xlane_node #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_node (
      .clk  (clk),
      .kind (nk),
      .a_val(av),
      .a_idx(ai),
      .b_val(bv),
      .b_idx(bi),
      .y_val(node_v[i]),
      .y_idx(node_i[i])
    );
  end

  assign root_val = node_v[1];
  assign root_idx = node_i[1];

endmodule

// File: rtl/xlane_side.sv
module xlane_side
  import xlane_pkg::*;
#(
  parameter int PRED_W = 64,
  parameter int N_W    = 7,
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  fold_op_e          op_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic [N_W-1:0]    n_i,
  output logic              valid_o,
  output fold_op_e          op_o,
  output logic              bit_o,
  output logic [PRED_W-1:0] tail_o
);

  typedef struct packed {
    logic           vld;
    fold_op_e       op;
    logic           fbit;
    logic [N_W-1:0] n;
  } side_t;

  side_t pipe [STAGES];
  side_t head;

  // The predicate is folded on entry; only one bit rides the pipe.
  always_comb begin
    head.vld  = valid_i;
    head.op   = op_i;
    head.fbit = (op_i == OP_ALL) ? (&pred_i) : (|pred_i);
    head.n    = n_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= head;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign valid_o = pipe[STAGES-1].vld;
  assign op_o    = pipe[STAGES-1].op;
  assign bit_o   = pipe[STAGES-1].fbit;

  // Tail mask expanded at the exit from the delayed count.
  for (genvar l = 0; l < PRED_W; l++) begin : g_tail
    assign tail_o[l] = (int'(pipe[STAGES-1].n) > l);
  end

endmodule

// File: rtl/xlane_fold.sv
module xlane_fold
  import xlane_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int DATA_W = 16,
  parameter int PRED_W = 64,
  parameter int N_W    = 7,
  parameter int RES_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2:0]              op_i,
  input  logic [LANES*DATA_W-1:0] vec_i,
  input  logic [PRED_W-1:0]       pred_i,
  input  logic [N_W-1:0]          n_i,
  output logic                    out_valid,
  output logic [RES_W-1:0]        res_o,
  output logic [LANES-1:0]        lane_mask_o,
  output logic                    flag_o,
  output logic [PRED_W-1:0]       tail_o
);

  localparam int LEVELS = $clog2(LANES);
  localparam int ACC_W  = DATA_W + LEVELS;
  localparam int HB_W   = ACC_W - DATA_W;

  fold_op_e op_in;
  assign op_in = fold_op_e'(op_i);

  logic [ACC_W-1:0]  root_val;
  logic [LEVELS-1:0] root_idx;

  xlane_tree #(.LANES(LANES), .DATA_W(DATA_W)) u_tree (
    .clk     (clk),
    .kind_i  (kind_of(op_in)),
    .vec_i   (vec_i),
    .root_val(root_val),
    .root_idx(root_idx)
  );

  logic              s_valid, s_bit;
  fold_op_e          s_op;
  logic [PRED_W-1:0] s_tail;

  xlane_side #(.PRED_W(PRED_W), .N_W(N_W), .STAGES(LEVELS)) u_side (
    .clk    (clk),
    .rst    (rst),
    .valid_i(in_valid),
    .op_i   (op_in),
    .pred_i (pred_i),
    .n_i    (n_i),
    .valid_o(s_valid),
    .op_o   (s_op),
    .bit_o  (s_bit),
    .tail_o (s_tail)
  );

  // Output formatting: saturation once on the exact sum, unbias extrema.
  logic [DATA_W-1:0] ext16, sat16;
  logic [HB_W-1:0]   hb;
  logic              sgn;
  logic [RES_W-1:0]  res_c;
  logic [LANES-1:0]  mask_c;
  logic              flag_c;

  always_comb begin
    ext16 = {~root_val[DATA_W-1], root_val[DATA_W-2:0]};
    sgn   = root_val[ACC_W-1];
    hb    = root_val[ACC_W-2:DATA_W-1];
    if (!sgn && (|hb))      sat16 = {1'b0, {(DATA_W-1){1'b1}}};
    else if (sgn && !(&hb)) sat16 = {1'b1, {(DATA_W-1){1'b0}}};
    else                    sat16 = root_val[DATA_W-1:0];

    res_c  = '0;
    mask_c = '0;
    flag_c = 1'b0;
    case (s_op)
      OP_SUM:  res_c = RES_W'($signed(root_val));
      OP_SSUM: res_c = RES_W'($signed(sat16));
      OP_MAX, OP_MIN: res_c = RES_W'($signed(ext16));
      OP_AMAX, OP_AMIN: begin
        res_c = RES_W'($signed(ext16));
        mask_c[root_idx] = 1'b1;
      end
      default: flag_c = s_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      res_o       <= '0;
      lane_mask_o <= '0;
      flag_o      <= 1'b0;
      tail_o      <= '0;
    end else begin
      out_valid   <= s_valid;
      res_o       <= res_c;
      lane_mask_o <= mask_c;
      flag_o      <= flag_c;
      tail_o      <= s_tail;
    end
  end

endmodule

// File: rtl/xlane_fold_chk.sv
module xlane_fold_chk
  import xlane_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int PRED_W = 64,
  parameter int RES_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op_i,
  input logic              out_valid,
  input logic [RES_W-1:0]  res_o,
  input logic [LANES-1:0]  lane_mask_o,
  input logic              flag_o,
  input logic [PRED_W-1:0] tail_o
);

  localparam int LAT = $clog2(LANES) + 1;

  logic       vq [LAT];
  logic [2:0] oq [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < LAT; s++) begin
        vq[s] <= 1'b0;
        oq[s] <= '0;
      end
    end else begin
      vq[0] <= in_valid;
      oq[0] <= op_i;
      for (int s = 1; s < LAT; s++) begin
        vq[s] <= vq[s-1];
        oq[s] <= oq[s-1];
      end
    end
  end

  logic [2:0] oo;
  logic       is_arg, is_bool, is_ext;
  assign oo      = oq[LAT-1];
  assign is_arg  = (oo == OP_AMAX) || (oo == OP_AMIN);
  assign is_ext  = (oo == OP_MAX) || (oo == OP_MIN) || is_arg;
  assign is_bool = (oo == OP_ALL) || (oo == OP_ANY);

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vq[LAT-1]);

  a_r3_sat_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && oo == OP_SSUM) |-> (res_o[RES_W-1:15] == '0 || res_o[RES_W-1:15] == '1));

  a_r4_no_widen: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_ext) |-> (res_o[RES_W-1:15] == '0 || res_o[RES_W-1:15] == '1));

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_arg) |-> $onehot(lane_mask_o));

  a_r5_mask_idle: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !is_arg) |-> (lane_mask_o == '0));

  a_r7_flag_only_bool: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !is_bool) |-> !flag_o);

  a_r7_res_zero_bool: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_bool) |-> (res_o == '0));

  a_r8_tail_thermo: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((tail_o & (tail_o + 1'b1)) == '0));

endmodule

bind xlane_fold xlane_fold_chk #(
  .LANES(LANES), .PRED_W(PRED_W), .RES_W(RES_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_i       (op_i),
  .out_valid  (out_valid),
  .res_o      (res_o),
  .lane_mask_o(lane_mask_o),
  .flag_o     (flag_o),
  .tail_o     (tail_o)
);

// File: tb/tb_xlane_fold.sv
`timescale 1ns/1ps
module tb_xlane_fold;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   op_i = '0;
  logic [511:0] vec_i = '0;
  logic [63:0]  pred_i = '0;
  logic [6:0]   n_i = '0;
  logic [3:0]   ph_i = '0;
  logic         out_valid;
  logic [31:0]  res_o;
  logic [31:0]  lane_mask_o;
  logic         flag_o;
  logic [63:0]  tail_o;

  always #10 clk = ~clk;

  xlane_fold dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i), .vec_i(vec_i),
    .pred_i(pred_i), .n_i(n_i), .out_valid(out_valid), .res_o(res_o),
    .lane_mask_o(lane_mask_o), .flag_o(flag_o), .tail_o(tail_o)
  );

  typedef struct packed {
    logic        v;
    logic [2:0]  op;
    logic [3:0]  ph;
    logic [31:0] res;
    logic [31:0] mask;
    logic        flag;
    logic [63:0] tail;
  } exp_t;

  integer checks = 0;
  integer fails  = 0;
  logic   started = 1'b0;
  logic   done = 1'b0;
  exp_t   ep [6];

  // Flat behavioural reference.
  function automatic exp_t model(logic v, logic [2:0] op, logic [511:0] vec,
                                 logic [63:0] pred, logic [6:0] n, logic [3:0] ph);
    exp_t e;
    integer s, best, bi, x;
    e = '0;
    e.v = v; e.op = op; e.ph = ph;
    s = 0;
    for (int k = 0; k < 32; k++) s = s + $signed(vec[16*k +: 16]);
    best = $signed(vec[15:0]);
    bi = 0;
    for (int k = 1; k < 32; k++) begin
      x = $signed(vec[16*k +: 16]);
      if ((op == 3'd2 || op == 3'd4) && x > best) begin best = x; bi = k; end
      if ((op == 3'd3 || op == 3'd5) && x < best) begin best = x; bi = k; end
    end
    case (op)
      3'd0: e.res = s;
      3'd1: e.res = (s > 32767) ? 32767 : (s < -32768) ? -32768 : s;
      3'd2, 3'd3: e.res = best;
      3'd4, 3'd5: begin e.res = best; e.mask = 32'd1 << bi; end
      3'd6: e.flag = (pred == '1);
      default: e.flag = (pred != '0);
    endcase
    for (int l = 0; l < 64; l++) e.tail[l] = (l < n);
    return e;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic string ph_tag(logic [3:0] ph);
    case (ph)
      4'd1: return " R6";
      4'd2: return " R5";
      4'd3: return " R3";
      default: return "";
    endcase
  endfunction

  task automatic chk(input string tag, input logic ok,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      for (int i = 0; i < 6; i++) ep[i] <= '0;
    end else begin
      for (int i = 5; i > 0; i--) ep[i] <= ep[i-1];
      ep[0] <= model(in_valid, op_i, vec_i, pred_i, n_i, ph_i);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      if (rst) begin
        chk("R9 reset", !out_valid && res_o == 0 && lane_mask_o == 0 && !flag_o && tail_o == 0,
            {31'd0, out_valid, res_o}, 64'd0);
      end else begin
        chk("R1 valid", out_valid == ep[5].v, {63'd0, out_valid}, {63'd0, ep[5].v});
        if (ep[5].v) begin
          chk({tag_of(ep[5].op), ph_tag(ep[5].ph), " res"}, res_o == ep[5].res,
              {32'd0, res_o}, {32'd0, ep[5].res});
          chk({"R5", ph_tag(ep[5].ph), " mask"}, lane_mask_o == ep[5].mask,
              {32'd0, lane_mask_o}, {32'd0, ep[5].mask});
          chk("R7 flag", flag_o == ep[5].flag, {63'd0, flag_o}, {63'd0, ep[5].flag});
          chk("R8 tail", tail_o == ep[5].tail, tail_o, ep[5].tail);
        end
      end
    end
  end

  task automatic send(input logic v, input logic [2:0] op, input logic [511:0] vec,
                      input logic [63:0] pred, input logic [6:0] n, input logic [3:0] ph);
    in_valid = v; op_i = op; vec_i = vec; pred_i = pred; n_i = n; ph_i = ph;
    @(negedge clk);
  endtask

  function automatic logic [511:0] fill(input logic [15:0] x);
    logic [511:0] r;
    for (int k = 0; k < 32; k++) r[16*k +: 16] = x;
    return r;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [511:0] v;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // Widening and saturating sum extremes (R2, R3).
    send(1, 3'd0, fill(16'h7fff), '0, 7'd0, 0);
    send(1, 3'd1, fill(16'h7fff), '0, 7'd1, 0);
    send(1, 3'd0, fill(16'h8000), '0, 7'd63, 0);
    send(1, 3'd1, fill(16'h8000), '0, 7'd64, 0);
    // Partial sums overflow but the total (-16) fits: R3 single clamp.
    v = '0;
    for (int k = 0; k < 32; k++) v[16*k +: 16] = (k < 16) ? 16'h7fff : 16'h8000;
    send(1, 3'd1, v, '0, 7'd100, 3);
    send(1, 3'd0, v, '0, 7'd127, 3);

    // Signed ordering (R6): -1, 0, -32768 among -5.
    v = fill(16'hfffb);
    v[16*3 +: 16] = 16'hffff;
    v[16*7 +: 16] = 16'h0000;
    v[16*9 +: 16] = 16'h8000;
    for (int o = 2; o < 6; o++) send(1, 3'(o), v, '0, 7'd5, 1);

    // Tie-breaking toward the lower lane (R5).
    send(1, 3'd4, fill(16'h7fff), '0, 7'd2, 2);
    send(1, 3'd5, fill(16'h1234), '0, 7'd2, 2);
    v = fill(16'd0);
    v[16*5 +: 16] = 16'd100;
    v[16*31 +: 16] = 16'd100;
    v[16*30 +: 16] = 16'hff00;
    v[16*12 +: 16] = 16'hff00;
    send(1, 3'd4, v, '0, 7'd3, 2);
    send(1, 3'd5, v, '0, 7'd3, 2);

    // Boolean folds (R7).
    send(1, 3'd6, v, '1, 7'd64, 0);
    send(1, 3'd6, v, 64'hffff_ffff_7fff_ffff, 7'd64, 0);
    send(1, 3'd7, v, '0, 7'd0, 0);
    send(1, 3'd7, v, 64'h8000_0000_0000_0000, 7'd65, 0);

    // Bubbles, then random stream (R1, all ops).
    send(0, 3'd0, v, '0, 7'd9, 0);
    send(0, 3'd3, v, '0, 7'd9, 0);
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
      if (i % 7 == 0) v[15:0] = 16'h8000;
      send(($urandom % 4) != 0, 3'($urandom), v,
           (i % 3 == 0) ? '1 : {$urandom, $urandom}, 7'($urandom), 0);
    end
    send(0, 3'd0, '0, '0, 7'd0, 0);
    repeat (8) @(negedge clk);
    finish_run();
  end

endmodule